// File: doc/BRIEF.md
# Privileged Trap Entry Controller

This block takes a trap request and works out the new trap state in one clock. A request is an interrupt flag, a cause code and a faulting address. The block picks the handling level, supervisor or machine. It then produces the updated status fields, the cause word, the exception PC and the trap value. It also forms the new PC from the vector base of the chosen level and gives the new privilege.

The surrounding core supplies the current PC, privilege, status bits, both delegation masks and both vector bases. It writes the registered results into its own state on the cycle in which `done_o` is high. `to_s_o` says whether the cause, exception-PC and trap-value words go to the supervisor copies or the machine copies. The status outputs are the full status word after the update: only the fields of the handling level change, and the fields of the other level pass through unchanged.

Privilege encoding: 0 is user, 1 is supervisor, 3 is machine.

Top module: `trap_entry_ctrl`

## Requirements
- R1: An interrupt request looks up its cause in `irq_deleg_i`. An exception request looks up its cause in `exc_deleg_i`. The other mask has no effect on the result.
- R2: The trap goes to supervisor level (`to_s_o`=1) only when all three of these hold: the current privilege is 0 or 1, the final cause is below XLEN, and the mask bit at that cause is 1. In every other case it goes to machine level.
- R3: When the trap goes to supervisor level, the outputs change as follows: `spie_o` takes the old `st_sie_i`, `spp_o` takes bit 0 of the old privilege, and `sie_o` becomes 0. When it goes to machine level, `mpie_o` takes the old `st_mie_i`, `mpp_o` takes the old privilege, and `mie_o` becomes 0. All other status outputs copy their inputs.
- R4: `cause_o` holds the final cause in its low bits and has zeros above them. Its bit XLEN-1 is 1 for an interrupt and 0 for an exception.
- R5: `epc_o` equals the `pc_i` value that came with the request.
- R6: `pc_o` is the vector base of the handling level with bits [1:0] cleared. The block adds 4 times the cause to it only for an interrupt whose base has bits [1:0] = 01. Mode values 00, 10 and 11 add nothing.
- R7: `tval_o` equals `trap_addr_i` for exception causes 0, 1, 4, 5, 6, 7, 12, 13 and 15. It is 0 for every other exception cause and for every interrupt.
- R8: An exception with code 8 (generic environment call) is rewritten to cause 8 + privilege before delegation. Privilege 0 gives 8, privilege 1 gives 9 and privilege 3 gives 11.
- R9: `priv_o` becomes 1 for a supervisor-level trap and 3 for a machine-level trap.
- R10: `done_o` is high in the cycle after a clock edge that sampled `trap_valid_i`=1. When no request is sampled, `done_o` is 0 and all other outputs keep their values. After reset, `done_o`=0, `priv_o`=3 and `pc_o`=0.
- R11: With parameter VECTORED_EN=0, `pc_o` is always the cleared base, even for a vectored-mode interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| trap_valid_i | input | 1 | trap request strobe |
| trap_irq_i | input | 1 | 1 = interrupt, 0 = exception |
| trap_code_i | input | CAUSE_W | raw cause code |
| trap_addr_i | input | XLEN | faulting address |
| pc_i | input | XLEN | PC of the trapping instruction |
| priv_i | input | 2 | current privilege |
| st_sie_i | input | 1 | supervisor interrupt enable |
| st_spie_i | input | 1 | supervisor previous enable |
| st_spp_i | input | 1 | supervisor previous privilege |
| st_mie_i | input | 1 | machine interrupt enable |
| st_mpie_i | input | 1 | machine previous enable |
| st_mpp_i | input | 2 | machine previous privilege |
| irq_deleg_i | input | XLEN | interrupt delegation mask |
| exc_deleg_i | input | XLEN | exception delegation mask |
| stvec_i | input | XLEN | supervisor vector base and mode |
| mtvec_i | input | XLEN | machine vector base and mode |
| done_o | output | 1 | results valid this cycle |
| to_s_o | output | 1 | 1 = handled at supervisor level |
| priv_o | output | 2 | new privilege |
| sie_o | output | 1 | new supervisor enable |
| spie_o | output | 1 | new supervisor previous enable |
| spp_o | output | 1 | new supervisor previous privilege |
| mie_o | output | 1 | new machine enable |
| mpie_o | output | 1 | new machine previous enable |
| mpp_o | output | 2 | new machine previous privilege |
| cause_o | output | XLEN | cause word |
| epc_o | output | XLEN | exception PC |
| tval_o | output | XLEN | trap value |
| pc_o | output | XLEN | handler PC |

## Verification
The hardest case to reach is an interrupt and an exception with the same cause number but opposite delegation masks. Only the mask that matches the trap kind may decide the level. The bench sets bit 5 in one mask only and sends both kinds of trap. A second case is a cause of 32 or more, which has no bit in a 32-bit mask. The bench sends cause 40 from user level with an all-ones mask, and the trap must still go to machine level. Vectored mode is exercised with the mode bits set on both bases: exceptions must ignore those bits, and a second instance built with VECTORED_EN=0 must never add the offset.

// File: rtl/trap_pkg.sv
package trap_pkg;
   typedef enum logic [1:0] {
      PRV_USER  = 2'd0,
      PRV_SUPER = 2'd1,
      PRV_RSVD  = 2'd2,
      PRV_MACH  = 2'd3
   } prv_e;

   localparam int unsigned EXC_FETCH_MIS  = 0;
   localparam int unsigned EXC_FETCH_ACC  = 1;
   localparam int unsigned EXC_LOAD_MIS   = 4;
   localparam int unsigned EXC_LOAD_ACC   = 5;
   localparam int unsigned EXC_STORE_MIS  = 6;
   localparam int unsigned EXC_STORE_ACC  = 7;
   localparam int unsigned EXC_ENV_CALL   = 8;
   localparam int unsigned EXC_FETCH_PGF  = 12;
   localparam int unsigned EXC_LOAD_PGF   = 13;
   localparam int unsigned EXC_STORE_PGF  = 15;

   localparam logic [1:0] VEC_MODE_SPREAD = 2'b01;
endpackage

// File: rtl/trap_code_norm.sv
module trap_code_norm #(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned CAUSE_W = 6
) (
   input  logic               is_irq_i,
   input  logic [CAUSE_W-1:0] code_i,
   input  logic [1:0]         priv_i,
   input  logic [XLEN-1:0]    addr_i,
   output logic [CAUSE_W-1:0] cause_o,
   output logic [XLEN-1:0]    tval_o
);
   import trap_pkg::*;

   localparam logic [CAUSE_W-1:0] ENV_CODE = CAUSE_W'(EXC_ENV_CALL);

   logic carries_addr;

   // environment call rewritten by privilege (R8)
   always_comb begin
      cause_o = code_i;
      if (!is_irq_i && code_i == ENV_CODE)
         cause_o = ENV_CODE + CAUSE_W'(priv_i);
   end

   // causes that carry the faulting address (R7)
   always_comb begin
      carries_addr = 1'b0;
      if (!is_irq_i) begin
         unique case (int'(cause_o))
            EXC_FETCH_MIS, EXC_FETCH_ACC, EXC_LOAD_MIS, EXC_LOAD_ACC,
            EXC_STORE_MIS, EXC_STORE_ACC, EXC_FETCH_PGF, EXC_LOAD_PGF,
            EXC_STORE_PGF: carries_addr = 1'b1;
            default:       carries_addr = 1'b0;
         endcase
      end
   end

   assign tval_o = carries_addr ? addr_i : '0;
endmodule

// File: rtl/trap_target_sel.sv
module trap_target_sel #(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned CAUSE_W = 6
) (
   input  logic               is_irq_i,
   input  logic [CAUSE_W-1:0] cause_i,
   input  logic [1:0]         priv_i,
   input  logic [XLEN-1:0]    irq_deleg_i,
   input  logic [XLEN-1:0]    exc_deleg_i,
   output logic               to_s_o
);
   import trap_pkg::*;

   localparam int unsigned IDX_W = $clog2(XLEN);

   logic [XLEN-1:0]  mask;
   logic [IDX_W-1:0] idx;
   logic             in_range;
   logic             low_priv;

   // R1: the mask follows the trap kind
   assign mask     = is_irq_i ? irq_deleg_i : exc_deleg_i;
   assign low_priv = (priv_i == PRV_USER) || (priv_i == PRV_SUPER);

   generate
      if (CAUSE_W > IDX_W) begin : g_wide_cause
         assign idx      = cause_i[IDX_W-1:0];
         assign in_range = (cause_i[CAUSE_W-1:IDX_W] == '0);
      end else if (CAUSE_W == IDX_W) begin : g_equal_cause
         assign idx      = cause_i;
         assign in_range = 1'b1;
      end else begin : g_narrow_cause
         assign idx      = {{(IDX_W-CAUSE_W){1'b0}}, cause_i};
         assign in_range = 1'b1;
      end
   endgenerate

   // R2: supervisor only from low privilege, in range, bit set
   assign to_s_o = low_priv && in_range && mask[idx];
endmodule

// File: rtl/trap_vec_gen.sv
module trap_vec_gen #(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned CAUSE_W     = 6,
   parameter bit          VECTORED_EN = 1'b1
) (
   input  logic               is_irq_i,
   input  logic [CAUSE_W-1:0] cause_i,
   input  logic [XLEN-1:0]    tvec_i,
   output logic [XLEN-1:0]    pc_o
);
   import trap_pkg::*;

   logic [XLEN-1:0] base;
   logic [XLEN-1:0] offset;

   assign base = {tvec_i[XLEN-1:2], 2'b00};

   generate
      if (VECTORED_EN) begin : g_vectored
         always_comb begin
            offset = '0;
            if (is_irq_i && tvec_i[1:0] == VEC_MODE_SPREAD)
               offset[CAUSE_W+1:0] = {cause_i, 2'b00};
         end
      end else begin : g_direct
         logic unused_bits;
         assign unused_bits = ^{is_irq_i, cause_i, tvec_i[1:0]};
         assign offset = '0;
      end
   endgenerate

   assign pc_o = base + offset;
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl #(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned CAUSE_W     = 6,
   parameter bit          VECTORED_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trap_valid_i,
   input  logic               trap_irq_i,
   input  logic [CAUSE_W-1:0] trap_code_i,
   input  logic [XLEN-1:0]    trap_addr_i,
   input  logic [XLEN-1:0]    pc_i,
   input  logic [1:0]         priv_i,
   input  logic               st_sie_i,
   input  logic               st_spie_i,
   input  logic               st_spp_i,
   input  logic               st_mie_i,
   input  logic               st_mpie_i,
   input  logic [1:0]         st_mpp_i,
   input  logic [XLEN-1:0]    irq_deleg_i,
   input  logic [XLEN-1:0]    exc_deleg_i,
   input  logic [XLEN-1:0]    stvec_i,
   input  logic [XLEN-1:0]    mtvec_i,
   output logic               done_o,
   output logic               to_s_o,
   output logic [1:0]         priv_o,
   output logic               sie_o,
   output logic               spie_o,
   output logic               spp_o,
   output logic               mie_o,
   output logic               mpie_o,
   output logic [1:0]         mpp_o,
   output logic [XLEN-1:0]    cause_o,
   output logic [XLEN-1:0]    epc_o,
   output logic [XLEN-1:0]    tval_o,
   output logic [XLEN-1:0]    pc_o
);
   import trap_pkg::*;

   localparam int unsigned PAD_W = XLEN - 1 - CAUSE_W;

   generate
      if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
         $error("trap_entry_ctrl: XLEN must be 32 or 64");
      end
      if (CAUSE_W < 4 || CAUSE_W + 2 > XLEN - 1) begin : g_bad_cause
         $error("trap_entry_ctrl: CAUSE_W out of range");
      end
   endgenerate

   logic [CAUSE_W-1:0] cause_fin;
   logic [XLEN-1:0]    tval_nx;
   logic               to_s_nx;
   logic [XLEN-1:0]    tvec_sel;
   logic [XLEN-1:0]    pc_nx;

   trap_code_norm #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_norm (
      .is_irq_i (trap_irq_i),
      .code_i   (trap_code_i),
      .priv_i   (priv_i),
      .addr_i   (trap_addr_i),
      .cause_o  (cause_fin),
      .tval_o   (tval_nx)
   );

   trap_target_sel #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_sel (
      .is_irq_i    (trap_irq_i),
      .cause_i     (cause_fin),
      .priv_i      (priv_i),
      .irq_deleg_i (irq_deleg_i),
      .exc_deleg_i (exc_deleg_i),
      .to_s_o      (to_s_nx)
   );

   assign tvec_sel = to_s_nx ? stvec_i : mtvec_i;

   trap_vec_gen #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .VECTORED_EN(VECTORED_EN)) u_vec (
      .is_irq_i (trap_irq_i),
      .cause_i  (cause_fin),
      .tvec_i   (tvec_sel),
      .pc_o     (pc_nx)
   );

   // status update for the handling level (R3)
   logic       sie_nx, spie_nx, spp_nx, mie_nx, mpie_nx;
   logic [1:0] mpp_nx;

   always_comb begin
      sie_nx  = st_sie_i;
      spie_nx = st_spie_i;
      spp_nx  = st_spp_i;
      mie_nx  = st_mie_i;
      mpie_nx = st_mpie_i;
      mpp_nx  = st_mpp_i;
      if (to_s_nx) begin
         spie_nx = st_sie_i;
         spp_nx  = priv_i[0];
         sie_nx  = 1'b0;
      end else begin
         mpie_nx = st_mie_i;
         mpp_nx  = priv_i;
         mie_nx  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o  <= 1'b0;
         to_s_o  <= 1'b0;
         priv_o  <= PRV_MACH;
         sie_o   <= 1'b0;
         spie_o  <= 1'b0;
         spp_o   <= 1'b0;
         mie_o   <= 1'b0;
         mpie_o  <= 1'b0;
         mpp_o   <= 2'b00;
         cause_o <= '0;
         epc_o   <= '0;
         tval_o  <= '0;
         pc_o    <= '0;
      end else begin
         done_o <= trap_valid_i;
         if (trap_valid_i) begin
            to_s_o  <= to_s_nx;
            priv_o  <= to_s_nx ? PRV_SUPER : PRV_MACH;
            sie_o   <= sie_nx;
            spie_o  <= spie_nx;
            spp_o   <= spp_nx;
            mie_o   <= mie_nx;
            mpie_o  <= mpie_nx;
            mpp_o   <= mpp_nx;
            cause_o <= {trap_irq_i, {PAD_W{1'b0}}, cause_fin};
            epc_o   <= pc_i;
            tval_o  <= tval_nx;
            pc_o    <= pc_nx;
         end
      end
   end
endmodule

// File: rtl/trap_entry_ctrl_chk.sv
module trap_entry_ctrl_chk #(
   parameter int unsigned XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            trap_valid_i,
   input logic            trap_irq_i,
   input logic [XLEN-1:0] pc_i,
   input logic [1:0]      priv_i,
   input logic [XLEN-1:0] stvec_i,
   input logic [XLEN-1:0] mtvec_i,
   input logic            done_o,
   input logic            to_s_o,
   input logic [1:0]      priv_o,
   input logic            sie_o,
   input logic            mie_o,
   input logic [XLEN-1:0] cause_o,
   input logic [XLEN-1:0] epc_o,
   input logic [XLEN-1:0] tval_o,
   input logic [XLEN-1:0] pc_o
);
   assert_done_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid_i |=> done_o);

   assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_valid_i |=> (!done_o && $stable(pc_o) && $stable(cause_o)));

   assert_epc_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid_i |=> (epc_o == $past(pc_i)));

   assert_new_priv_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (to_s_o ? (priv_o == 2'd1) : (priv_o == 2'd3)));

   assert_ie_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (to_s_o ? !sie_o : !mie_o));

   assert_cause_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid_i |=> (cause_o[XLEN-1] == $past(trap_irq_i)));

   assert_irq_no_tval_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid_i && trap_irq_i) |=> (tval_o == '0));

   assert_mach_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid_i && priv_i == 2'd3) |=> !to_s_o);

   assert_exc_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid_i && !trap_irq_i) |=>
         (pc_o[1:0] == 2'b00 &&
          pc_o[XLEN-1:2] == (to_s_o ? $past(stvec_i[XLEN-1:2]) : $past(mtvec_i[XLEN-1:2]))));
endmodule

bind trap_entry_ctrl trap_entry_ctrl_chk #(.XLEN(XLEN)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .trap_valid_i (trap_valid_i),
   .trap_irq_i   (trap_irq_i),
   .pc_i         (pc_i),
   .priv_i       (priv_i),
   .stvec_i      (stvec_i),
   .mtvec_i      (mtvec_i),
   .done_o       (done_o),
   .to_s_o       (to_s_o),
   .priv_o       (priv_o),
   .sie_o        (sie_o),
   .mie_o        (mie_o),
   .cause_o      (cause_o),
   .epc_o        (epc_o),
   .tval_o       (tval_o),
   .pc_o         (pc_o)
);

// File: tb/sim_trap_entry_ctrl.sv
`timescale 1ns/1ps
module sim_trap_entry_ctrl;
   localparam int XLEN = 32;
   localparam int CW   = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            valid = 1'b0;
   logic            irq = 1'b0;
   logic [CW-1:0]   code = '0;
   logic [XLEN-1:0] addr = 32'hDEAD_BEE0;
   logic [XLEN-1:0] pc = 32'h8000_1000;
   logic [1:0]      priv = 2'd3;
   logic            s_sie = 1'b1, s_spie = 1'b0, s_spp = 1'b1;
   logic            s_mie = 1'b1, s_mpie = 1'b0;
   logic [1:0]      s_mpp = 2'd0;
   logic [XLEN-1:0] ideleg = '0, edeleg = '0;
   logic [XLEN-1:0] stvec = 32'h0000_4001, mtvec = 32'h0000_8001;

   logic            done, to_s, sie, spie, spp, mie, mpie;
   logic [1:0]      npriv, mpp;
   logic [XLEN-1:0] cause, epc, tval, npc;
   logic            d1, ts1, a1, b1, c1, e1, f1;
   logic [1:0]      p1, g1;
   logic [XLEN-1:0] ca1, ep1, tv1, pc1;

   int checks = 0;
   int bad = 0;

   always #5 clk = ~clk;

   trap_entry_ctrl #(.XLEN(XLEN), .CAUSE_W(CW), .VECTORED_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .trap_valid_i(valid), .trap_irq_i(irq),
      .trap_code_i(code), .trap_addr_i(addr), .pc_i(pc), .priv_i(priv),
      .st_sie_i(s_sie), .st_spie_i(s_spie), .st_spp_i(s_spp),
      .st_mie_i(s_mie), .st_mpie_i(s_mpie), .st_mpp_i(s_mpp),
      .irq_deleg_i(ideleg), .exc_deleg_i(edeleg), .stvec_i(stvec), .mtvec_i(mtvec),
      .done_o(done), .to_s_o(to_s), .priv_o(npriv), .sie_o(sie), .spie_o(spie),
      .spp_o(spp), .mie_o(mie), .mpie_o(mpie), .mpp_o(mpp),
      .cause_o(cause), .epc_o(epc), .tval_o(tval), .pc_o(npc));

   trap_entry_ctrl #(.XLEN(XLEN), .CAUSE_W(CW), .VECTORED_EN(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .trap_valid_i(valid), .trap_irq_i(irq),
      .trap_code_i(code), .trap_addr_i(addr), .pc_i(pc), .priv_i(priv),
      .st_sie_i(s_sie), .st_spie_i(s_spie), .st_spp_i(s_spp),
      .st_mie_i(s_mie), .st_mpie_i(s_mpie), .st_mpp_i(s_mpp),
      .irq_deleg_i(ideleg), .exc_deleg_i(edeleg), .stvec_i(stvec), .mtvec_i(mtvec),
      .done_o(d1), .to_s_o(ts1), .priv_o(p1), .sie_o(a1), .spie_o(b1),
      .spp_o(c1), .mie_o(e1), .mpie_o(f1), .mpp_o(g1),
      .cause_o(ca1), .epc_o(ep1), .tval_o(tv1), .pc_o(pc1));

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // expected results built from the requirement text
   task automatic run_trap(input logic i_irq, input logic [CW-1:0] i_code,
                           input logic [1:0] i_priv, input string tag);
      int          fc;
      logic [31:0] mask;
      logic        exp_s, has_addr;
      logic [31:0] vbase, exp_pc;
      @(negedge clk);
      irq = i_irq; code = i_code; priv = i_priv; valid = 1'b1;
      fc = int'(i_code);
      if (!i_irq && fc == 8) fc = 8 + int'(i_priv);                      // R8
      mask = i_irq ? ideleg : edeleg;                                     // R1
      exp_s = (i_priv <= 2'd1) && (fc < 32) && mask[fc % 32];             // R2
      has_addr = !i_irq && (fc inside {0, 1, 4, 5, 6, 7, 12, 13, 15});    // R7
      vbase = (exp_s ? stvec : mtvec) & 32'hFFFF_FFFC;
      exp_pc = vbase;
      if (i_irq && (exp_s ? stvec[1:0] : mtvec[1:0]) == 2'b01)
         exp_pc = vbase + 32'(fc * 4);                                    // R6
      @(posedge clk);
      @(negedge clk);
      valid = 1'b0;
      chk("R10", {tag, " done"}, 64'(done), 64'd1);
      chk("R2",  {tag, " level"}, 64'(to_s), 64'(exp_s));
      chk("R9",  {tag, " priv"}, 64'(npriv), exp_s ? 64'd1 : 64'd3);
      chk("R4",  {tag, " cause"}, 64'(cause), 64'({i_irq, 25'd0, 6'(fc)}));
      chk("R5",  {tag, " epc"}, 64'(epc), 64'(pc));
      chk("R7",  {tag, " tval"}, 64'(tval), has_addr ? 64'(addr) : 64'd0);
      chk("R6",  {tag, " pc"}, 64'(npc), 64'(exp_pc));
      chk("R11", {tag, " pc novec"}, 64'(pc1), 64'(vbase));
      chk("R3",  {tag, " sie"},  64'(sie),  exp_s ? 64'd0 : 64'(s_sie));
      chk("R3",  {tag, " spie"}, 64'(spie), exp_s ? 64'(s_sie) : 64'(s_spie));
      chk("R3",  {tag, " spp"},  64'(spp),  exp_s ? 64'(i_priv[0]) : 64'(s_spp));
      chk("R3",  {tag, " mie"},  64'(mie),  exp_s ? 64'(s_mie) : 64'd0);
      chk("R3",  {tag, " mpie"}, 64'(mpie), exp_s ? 64'(s_mpie) : 64'(s_mie));
      chk("R3",  {tag, " mpp"},  64'(mpp),  exp_s ? 64'(s_mpp) : 64'(i_priv));
   endtask

   task automatic t_reset();
      chk("R10", "reset done", 64'(done), 64'd0);
      chk("R10", "reset priv", 64'(npriv), 64'd3);
      chk("R10", "reset pc", 64'(npc), 64'd0);
   endtask

   task automatic t_machine_exc();
      edeleg = '1; ideleg = '1;
      run_trap(1'b0, 6'd5, 2'd3, "mach-load-fault");
   endtask

   task automatic t_user_delegated();
      edeleg = 32'h1 << 13; ideleg = '0;
      run_trap(1'b0, 6'd13, 2'd0, "user-pgf");
      run_trap(1'b0, 6'd12, 2'd0, "user-pgf-undeleg");
   endtask

   task automatic t_mask_kind();
      ideleg = 32'h1 << 5; edeleg = '0;
      run_trap(1'b1, 6'd5, 2'd1, "irq5-vectored-R1");
      run_trap(1'b0, 6'd5, 2'd1, "exc5-other-mask-R1");
      ideleg = '0; edeleg = 32'h1 << 5;
      run_trap(1'b1, 6'd5, 2'd0, "irq5-exc-mask-R1");
   endtask

   task automatic t_vector_modes();
      ideleg = '0; edeleg = '0;
      mtvec = 32'h0000_8003;
      run_trap(1'b1, 6'd7, 2'd3, "irq-mode3");
      mtvec = 32'h0000_8002;
      run_trap(1'b1, 6'd11, 2'd0, "irq-mode2");
      mtvec = 32'h0000_8001;
      run_trap(1'b1, 6'd11, 2'd0, "irq-mode1");
      run_trap(1'b0, 6'd0, 2'd3, "exc-mode1-fetch");
   endtask

   task automatic t_env_calls();
      edeleg = 32'h1 << 9; ideleg = '0;
      run_trap(1'b0, 6'd8, 2'd0, "ecall-user-R8");
      run_trap(1'b0, 6'd8, 2'd1, "ecall-super-R8");
      run_trap(1'b0, 6'd8, 2'd3, "ecall-mach-R8");
   endtask

   task automatic t_cause_range();
      edeleg = '1; ideleg = '1;
      run_trap(1'b0, 6'd40, 2'd0, "cause40-R2");
      run_trap(1'b1, 6'd33, 2'd1, "irq33-R2");
      run_trap(1'b0, 6'd31, 2'd0, "cause31-R2");
   endtask

   task automatic t_no_addr();
      edeleg = '0; ideleg = '0;
      run_trap(1'b0, 6'd2, 2'd1, "exc2-R7");
      run_trap(1'b0, 6'd3, 2'd0, "exc3-R7");
      run_trap(1'b0, 6'd7, 2'd0, "exc7-R7");
   endtask

   task automatic t_status_mix();
      s_sie = 1'b0; s_spie = 1'b1; s_spp = 1'b0;
      s_mie = 1'b0; s_mpie = 1'b1; s_mpp = 2'd1;
      edeleg = 32'h1 << 1;
      run_trap(1'b0, 6'd1, 2'd1, "status-s-R3");
      run_trap(1'b0, 6'd6, 2'd1, "status-m-R3");
   endtask

   task automatic t_idle_hold();
      logic [31:0] pc_was, cause_was;
      pc_was = npc; cause_was = cause;
      @(negedge clk);
      pc = 32'h1234_5678; mtvec = 32'h0000_F000; code = 6'd4;
      @(negedge clk);
      chk("R10", "idle done", 64'(done), 64'd0);
      chk("R10", "idle pc hold", 64'(npc), 64'(pc_was));
      chk("R10", "idle cause hold", 64'(cause), 64'(cause_was));
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_machine_exc();
      t_user_delegated();
      t_mask_kind();
      t_vector_modes();
      t_env_calls();
      t_cause_range();
      t_no_addr();
      t_status_mix();
      t_idle_hold();
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule